// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block gives a two-port shared memory a way for each side to signal the other. The two highest addresses of the array are reserved as mailboxes, and each port owns one of them. When one port writes the other port's mailbox, the owner's interrupt goes active. The interrupt stays active until the owner reads its own mailbox. The message itself lives in the ordinary memory array, and the block never sees its contents. The block only watches the write strobe, read strobe, address and busy input of each port.

The busy inputs come from the wrapper's contention arbiter. A port that has lost arbitration, so that its busy is high, cannot raise the other side's interrupt. It also cannot acknowledge its own interrupt.

Each interrupt is tracked by a small state machine with two states:

- FLAG_IDLE: no message is pending.
- FLAG_PENDING: a message is waiting for the owner.

There are two transitions:

- RAISE goes from FLAG_IDLE to FLAG_PENDING on an unblocked write by the other port to the mailbox.
- ACKNOWLEDGE goes from FLAG_PENDING to FLAG_IDLE on an unblocked read by the owner of its mailbox, when no RAISE happens in the same cycle.

In every other case the state holds. Each interrupt output is active-low and comes from a register.

Top module: `mbox_irq_ctrl`

## Requirements
- R1: After reset, both `p0_irq_n` and `p1_irq_n` are high (inactive).
- R2: The right (port 1) mailbox is the all-ones address, 2^ADDR_W-1 (0x3FFF by default). The left (port 0) mailbox is 2^ADDR_W-2 (0x3FFE). Accesses to any other address, including 0x3FFD, never change an interrupt.
- R3: A write by port 1 to 0x3FFE drives `p0_irq_n` low from the clock edge that samples it. A write by port 0 to 0x3FFF does the same for `p1_irq_n`.
- R4: A read by the owner of its own mailbox (port 0 at 0x3FFE, port 1 at 0x3FFF) drives its interrupt high from the clock edge that samples the read.
- R5: A read of the other port's mailbox, or a write by a port to its own mailbox, leaves both interrupts unchanged.
- R6: While the writing port's busy is high, its write to the other mailbox does not raise the owner's interrupt.
- R7: While the owner's busy is high, its read of its own mailbox does not clear its interrupt.
- R8: When a raise and an acknowledge of the same interrupt are sampled in the same cycle, the interrupt is active (low) afterwards.
- R9: With no raise or acknowledge sampled, an interrupt keeps its level from cycle to cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| p0_wr | input | 1 | Left port write strobe |
| p0_rd | input | 1 | Left port read strobe |
| p0_addr | input | ADDR_W | Left port address |
| p0_busy | input | 1 | Left port lost arbitration |
| p1_wr | input | 1 | Right port write strobe |
| p1_rd | input | 1 | Right port read strobe |
| p1_addr | input | ADDR_W | Right port address |
| p1_busy | input | 1 | Right port lost arbitration |
| p0_irq_n | output | 1 | Left port interrupt, active low |
| p1_irq_n | output | 1 | Right port interrupt, active low |

## Verification
Each interrupt is raised and cleared in both directions, which separates the two mailbox addresses from each other. Near-miss patterns probe the decode:

- Writes to the address just below the left mailbox.
- Writes by a port to its own mailbox.
- Reads of the peer's mailbox.

Together these catch an address compare that is off by one or a swapped owner. Busy is applied once on the writer and once on the owner, which tells set gating apart from clear gating. A raise and an acknowledge landing together show which of the two has priority.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;

    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    localparam int PORT_CNT = 2;

endpackage

// File: rtl/mbox_port_decode.sv
module mbox_port_decode #(
    parameter int                  ADDR_W  = 14,
    parameter logic [ADDR_W-1:0]   OWN_MB  = '1,
    parameter logic [ADDR_W-1:0]   PEER_MB = '0
) (
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output logic              peer_set,
    output logic              own_clr
);

    logic hit_own;
    logic hit_peer;

    always_comb begin
        hit_own  = (addr == OWN_MB);
        hit_peer = (addr == PEER_MB);
        // a write into the peer's box raises its flag unless arbitration was lost
        peer_set = wr && hit_peer && !busy;
        // reading one's own box acknowledges, again only when not busy
        own_clr  = rd && hit_own && !busy;
    end

endmodule

// File: rtl/mbox_irq_flag.sv
module mbox_irq_flag
    import mbox_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic clr_req,
    output logic irq_n
);

    flag_state_e st_q;
    flag_state_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FLAG_IDLE: begin
                if (set_req) st_d = FLAG_PENDING;           // RAISE
            end
            FLAG_PENDING: begin
                if (clr_req && !set_req) st_d = FLAG_IDLE;  // ACKNOWLEDGE
            end
            default: st_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= FLAG_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_n <= 1'b1;
        else        irq_n <= (st_d != FLAG_PENDING);
    end

    AST_SET_RAISES:   assert property (@(posedge clk) disable iff (!rst_n) set_req |=> !irq_n);              // R3
    AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n) clr_req && !set_req |=> irq_n);   // R4
    AST_SET_WINS:     assert property (@(posedge clk) disable iff (!rst_n) set_req && clr_req |=> !irq_n);   // R8
    AST_LEVEL_HOLDS:  assert property (@(posedge clk) disable iff (!rst_n) !set_req && !clr_req |=> $stable(irq_n)); // R9

endmodule

// File: rtl/mbox_irq_ctrl.sv
module mbox_irq_ctrl
    import mbox_irq_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              p0_wr,
    input  logic              p0_rd,
    input  logic [ADDR_W-1:0] p0_addr,
    input  logic              p0_busy,
    input  logic              p1_wr,
    input  logic              p1_rd,
    input  logic [ADDR_W-1:0] p1_addr,
    input  logic              p1_busy,
    output logic              p0_irq_n,
    output logic              p1_irq_n
);

    localparam logic [ADDR_W-1:0] MB_RIGHT = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MB_LEFT  = MB_RIGHT - ADDR_W'(1);

    logic              wr_v   [PORT_CNT];
    logic              rd_v   [PORT_CNT];
    logic [ADDR_W-1:0] addr_v [PORT_CNT];
    logic              busy_v [PORT_CNT];
    logic              set_v  [PORT_CNT];
    logic              clr_v  [PORT_CNT];
    logic              irq_v  [PORT_CNT];

    assign wr_v[0]   = p0_wr;
    assign rd_v[0]   = p0_rd;
    assign addr_v[0] = p0_addr;
    assign busy_v[0] = p0_busy;
    assign wr_v[1]   = p1_wr;
    assign rd_v[1]   = p1_rd;
    assign addr_v[1] = p1_addr;
    assign busy_v[1] = p1_busy;

    for (genvar g = 0; g < PORT_CNT; g++) begin : g_port
        localparam logic [ADDR_W-1:0] OWN_MB  = (g == 1) ? MB_RIGHT : MB_LEFT;
        localparam logic [ADDR_W-1:0] PEER_MB = (g == 1) ? MB_LEFT  : MB_RIGHT;

        mbox_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_MB  (OWN_MB),
            .PEER_MB (PEER_MB)
        ) u_dec (
            .wr       (wr_v[g]),
            .rd       (rd_v[g]),
            .addr     (addr_v[g]),
            .busy     (busy_v[g]),
            .peer_set (set_v[g]),
            .own_clr  (clr_v[g])
        );

        // the flag owned by port g is raised by the other port's decoder
        mbox_irq_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_req (set_v[PORT_CNT-1-g]),
            .clr_req (clr_v[g]),
            .irq_n   (irq_v[g])
        );
    end

    assign p0_irq_n = irq_v[0];
    assign p1_irq_n = irq_v[1];

    AST_BUSY_NO_SET_L: assert property (@(posedge clk) disable iff (!rst_n) p1_busy && p0_irq_n |=> p0_irq_n);   // R6
    AST_BUSY_NO_SET_R: assert property (@(posedge clk) disable iff (!rst_n) p0_busy && p1_irq_n |=> p1_irq_n);   // R6
    AST_BUSY_NO_CLR_L: assert property (@(posedge clk) disable iff (!rst_n) p0_busy && !p0_irq_n |=> !p0_irq_n); // R7
    AST_BUSY_NO_CLR_R: assert property (@(posedge clk) disable iff (!rst_n) p1_busy && !p1_irq_n |=> !p1_irq_n); // R7

endmodule

// File: tb/mbox_irq_ctrl_test.sv
module mbox_irq_ctrl_test;

    localparam int AW = 14;
    localparam logic [AW-1:0] LMB = 14'h3FFE;
    localparam logic [AW-1:0] RMB = 14'h3FFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p0_wr = 0, p0_rd = 0, p0_busy = 0;
    logic p1_wr = 0, p1_rd = 0, p1_busy = 0;
    logic [AW-1:0] p0_addr = '0, p1_addr = '0;
    logic p0_irq_n, p1_irq_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mbox_irq_ctrl #(.ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n),
        .p0_wr(p0_wr), .p0_rd(p0_rd), .p0_addr(p0_addr), .p0_busy(p0_busy),
        .p1_wr(p1_wr), .p1_rd(p1_rd), .p1_addr(p1_addr), .p1_busy(p1_busy),
        .p0_irq_n(p0_irq_n), .p1_irq_n(p1_irq_n)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    // drive one cycle of accesses at a falling edge, return after the next falling edge
    task automatic cyc(input logic w0, input logic r0, input logic [AW-1:0] a0, input logic b0,
                       input logic w1, input logic r1, input logic [AW-1:0] a1, input logic b1);
        p0_wr = w0; p0_rd = r0; p0_addr = a0; p0_busy = b0;
        p1_wr = w1; p1_rd = r1; p1_addr = a1; p1_busy = b1;
        @(negedge clk);
        p0_wr = 0; p0_rd = 0; p0_busy = 0; p0_addr = '0;
        p1_wr = 0; p1_rd = 0; p1_busy = 0; p1_addr = '0;
    endtask

    task automatic idle();
        cyc(0, 0, '0, 0, 0, 0, '0, 0);
    endtask

    task automatic t_reset();
        chk("R1", "left after reset", p0_irq_n, 1'b1);
        chk("R1", "right after reset", p1_irq_n, 1'b1);
    endtask

    task automatic t_left_box();
        cyc(0, 0, '0, 0, 1, 0, LMB, 0);
        chk("R3", "left raised", p0_irq_n, 1'b0);
        chk("R3", "right untouched", p1_irq_n, 1'b1);
        idle(); idle();
        chk("R9", "left holds", p0_irq_n, 1'b0);
        cyc(0, 0, '0, 0, 0, 1, LMB, 0);
        chk("R5", "peer read of left box", p0_irq_n, 1'b0);
        cyc(0, 1, RMB, 0, 0, 0, '0, 0);
        chk("R5", "left reads right box", p0_irq_n, 1'b0);
        chk("R5", "right stays clear", p1_irq_n, 1'b1);
        cyc(0, 1, LMB, 1, 0, 0, '0, 0);
        chk("R7", "busy owner read keeps left", p0_irq_n, 1'b0);
        cyc(0, 1, LMB, 0, 0, 0, '0, 0);
        chk("R4", "left acknowledged", p0_irq_n, 1'b1);
    endtask

    task automatic t_right_box();
        cyc(1, 0, RMB, 0, 0, 0, '0, 0);
        chk("R3", "right raised", p1_irq_n, 1'b0);
        chk("R3", "left untouched", p0_irq_n, 1'b1);
        cyc(0, 0, '0, 0, 0, 1, RMB, 1);
        chk("R7", "busy owner read keeps right", p1_irq_n, 1'b0);
        cyc(0, 0, '0, 0, 0, 1, RMB, 0);
        chk("R4", "right acknowledged", p1_irq_n, 1'b1);
    endtask

    task automatic t_near_miss();
        cyc(0, 0, '0, 0, 1, 0, 14'h3FFD, 0);
        chk("R2", "write below left box", p0_irq_n, 1'b1);
        cyc(0, 0, '0, 0, 1, 0, RMB, 0);
        chk("R5", "right writes own box (left)", p0_irq_n, 1'b1);
        chk("R5", "right writes own box (right)", p1_irq_n, 1'b1);
        cyc(1, 0, LMB, 0, 0, 0, '0, 0);
        chk("R5", "left writes own box (left)", p0_irq_n, 1'b1);
        chk("R5", "left writes own box (right)", p1_irq_n, 1'b1);
        cyc(1, 0, 14'h0000, 0, 1, 0, 14'h1FFF, 0);
        chk("R2", "ordinary writes left", p0_irq_n, 1'b1);
        chk("R2", "ordinary writes right", p1_irq_n, 1'b1);
    endtask

    task automatic t_busy_set();
        cyc(0, 0, '0, 0, 1, 0, LMB, 1);
        chk("R6", "busy writer no left raise", p0_irq_n, 1'b1);
        cyc(1, 0, RMB, 1, 0, 0, '0, 0);
        chk("R6", "busy writer no right raise", p1_irq_n, 1'b1);
    endtask

    task automatic t_set_wins();
        cyc(0, 1, LMB, 0, 1, 0, LMB, 0);
        chk("R8", "raise with ack from idle", p0_irq_n, 1'b0);
        cyc(0, 1, LMB, 0, 1, 0, LMB, 0);
        chk("R8", "raise with ack while pending", p0_irq_n, 1'b0);
        cyc(0, 1, LMB, 0, 0, 0, '0, 0);
        chk("R4", "left cleared after race", p0_irq_n, 1'b1);
        cyc(1, 0, RMB, 0, 0, 1, RMB, 0);
        chk("R8", "right raise with ack", p1_irq_n, 1'b0);
        cyc(0, 0, '0, 0, 0, 1, RMB, 0);
        chk("R4", "right cleared after race", p1_irq_n, 1'b1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_left_box();
        t_right_box();
        t_near_miss();
        t_busy_set();
        t_set_wins();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule